// File: doc/BRIEF.md
# Codec Control Register Mode Decoder

This block holds the host-written 16-bit run-mode control word of a speech codec engine. It turns the word into the effective enables that the codec datapath runs on. A write to the control address is captured at once into a read-only mirror, so the host can confirm that the write path works. The written value then goes through a settle delay, set by a parameter, that stands in for the time the engine takes to switch modes. When the delay ends, the resolved configuration is applied, a completion flag is raised in the status word, and the active-low interrupt line is pulled low if the interrupt is enabled.

Resolving the word means settling conflicting requests. When both the decode and encode bits are set, a half-duplex build goes idle and a full-duplex build runs both directions. Full duplex suppresses the tone generator and tone detector enables. The repeater enable is dropped whenever encoding is requested. Reserved bits are forced to zero.

While the settle delay runs, the block refuses every other host access. A refused write is dropped, a refused read returns zero, and both set a sticky error bit in the status word.

Top module: `codec_mode_ctrl`

## Requirements
- R1: A write to address 0x11 accepted while idle stores the raw 16-bit value, reserved bits included, in the mirror on the next clock. An idle read of address 0x3C returns the mirror. An idle read of 0x11 returns zero.
- R2: After an accepted write, `busy` is high for exactly SETTLE_CYC cycles. `mode_cfg` keeps its old value until the clock edge on which `busy` falls, and then holds the resolved value of the written word.
- R3: On the edge where `busy` falls, status bit 15 (done) becomes 1. `irq_n` is low exactly when done is 1 and `irq_enable` is 1.
- R4: An idle read of the status address 0x40 returns the current status word. The edge that ends the read clears done (bit 15) and the sticky error (bit 0), which releases `irq_n` high.
- R5: Any read or write while `busy` is high is refused. The write is dropped (neither the mirror nor the final configuration changes), the read returns zero, and status bit 0 (sticky error) is set.
- R6: Bits 15, 14 and 10 of `mode_cfg` are always zero.
- R7: With FULL_DUPLEX_OK=0, a word with bit 0 (decode) and bit 1 (encode) both set yields `mode_cfg` bits 1:0 = 00, and `full_duplex` stays low.
- R8: With FULL_DUPLEX_OK=1, a word with bits 1:0 = 11 keeps both bits, drives `full_duplex` high, and clears the tone enables in bits 13:11 and 9:5.
- R9: `mode_cfg` bit 2 (repeater) is cleared whenever bit 1 of the written word is set. Otherwise it follows the written bit 2. Bits 3 and 4 pass through unchanged.
- R10: Status bit 8 (frame wanted) equals `mode_cfg[4] & mode_cfg[0] & dec_ready`. All other status bits except 15 and 0 read zero.
- R11: A write to any address other than 0x11 has no effect: it starts no busy period, leaves the mirror unchanged and leaves `mode_cfg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 8 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid in the cycle `host_rd` is high |
| irq_enable | input | 1 | Lets the done flag drive the interrupt |
| dec_ready | input | 1 | Decoder can take another frame |
| irq_n | output | 1 | Active-low completion interrupt |
| busy | output | 1 | Command settle in progress |
| mode_cfg | output | 16 | Applied, resolved mode configuration |
| full_duplex | output | 1 | Both directions are running |

## Verification
The assertions assume the host raises `host_wr` and `host_rd` for one cycle per access. They also assume `host_wdata` is meaningful only when `host_wr` is high, and they do not check what happens when a read and a write land on the same edge. The bench drives every access from a task that holds each strobe for one clock and never overlaps the two. It then sweeps all 32 combinations of the five low mode bits against varied upper-bit patterns, with `irq_enable` and `dec_ready` alternating. Accesses that land inside a busy period are issued on purpose, only to check that they are refused.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int REG_W = 16;
  localparam int ADR_W = 8;

  // control word bit positions that downstream logic decodes
  localparam int B_DEC  = 0;
  localparam int B_ENC  = 1;
  localparam int B_RPT  = 2;
  localparam int B_WANT = 4;

  // status word bit positions
  localparam int ST_DONE = 15;
  localparam int ST_WANT = 8;
  localparam int ST_ERR  = 0;

  localparam logic [REG_W-1:0] RSVD_MASK = 16'hC400;
  localparam logic [REG_W-1:0] TONE_MASK = 16'h3BE0;

  typedef struct packed {
    logic [REG_W-1:0] cfg;
    logic             full;
  } mode_t;

  function automatic mode_t resolve_mode(input logic [REG_W-1:0] raw, input logic fd_ok);
    mode_t m;
    logic  both;
    both   = raw[B_DEC] & raw[B_ENC];
    m.cfg  = raw & ~RSVD_MASK;
    m.full = both & fd_ok;
    if (both && !fd_ok) begin
      m.cfg[B_DEC] = 1'b0;
      m.cfg[B_ENC] = 1'b0;
    end
    if (raw[B_ENC]) m.cfg[B_RPT] = 1'b0;
    if (m.full) m.cfg = m.cfg & ~TONE_MASK;
    return m;
  endfunction
endpackage

// File: rtl/cmc_host_port.sv
module cmc_host_port
  import cmc_pkg::*;
#(
  parameter logic [ADR_W-1:0] CTRL_ADDR = 8'h11,
  parameter logic [ADR_W-1:0] MIRR_ADDR = 8'h3C,
  parameter logic [ADR_W-1:0] STAT_ADDR = 8'h40
) (
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [ADR_W-1:0] host_addr,
  input  logic             busy,
  input  logic [REG_W-1:0] mirror,
  input  logic [REG_W-1:0] status,
  output logic             wr_accept,
  output logic             rd_status,
  output logic             reject,
  output logic [REG_W-1:0] host_rdata
);
  logic rd_ok;

  assign reject    = busy & (host_wr | host_rd);
  assign wr_accept = host_wr & ~busy & (host_addr == CTRL_ADDR);
  assign rd_ok     = host_rd & ~busy;
  assign rd_status = rd_ok & (host_addr == STAT_ADDR);

  always_comb begin
    host_rdata = '0;
    if (rd_ok) begin
      if (host_addr == MIRR_ADDR)      host_rdata = mirror;
      else if (host_addr == STAT_ADDR) host_rdata = status;
    end
  end
endmodule

// File: rtl/cmc_settle_timer.sv
module cmc_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic apply
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign apply = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= LOAD;
    end else if (apply) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cmc_mode_resolve.sv
module cmc_mode_resolve
  import cmc_pkg::*;
#(
  parameter bit FD_OK = 1'b0
) (
  input  logic [REG_W-1:0] raw,
  output logic [REG_W-1:0] cfg,
  output logic             full
);
  mode_t m;
  assign m    = resolve_mode(raw, FD_OK);
  assign cfg  = m.cfg;
  assign full = m.full;
endmodule

// File: rtl/codec_mode_ctrl.sv
module codec_mode_ctrl
  import cmc_pkg::*;
#(
  parameter bit                FULL_DUPLEX_OK = 1'b0,
  parameter int                SETTLE_CYC     = 2_500_000,
  parameter logic [ADR_W-1:0]  CTRL_ADDR      = 8'h11,
  parameter logic [ADR_W-1:0]  MIRR_ADDR      = 8'h3C,
  parameter logic [ADR_W-1:0]  STAT_ADDR      = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [ADR_W-1:0] host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             irq_enable,
  input  logic             dec_ready,
  output logic             irq_n,
  output logic             busy,
  output logic [REG_W-1:0] mode_cfg,
  output logic             full_duplex
);
  // named internal events
  logic             wr_accept;
  logic             rd_status;
  logic             reject;
  logic             apply_now;
  logic             frame_wanted;
  logic [REG_W-1:0] mirror_q;
  logic [REG_W-1:0] pend_q;
  logic [REG_W-1:0] res_cfg;
  logic             res_full;
  logic             done_q;
  logic             err_q;
  logic [REG_W-1:0] status;

  cmc_host_port #(
    .CTRL_ADDR(CTRL_ADDR), .MIRR_ADDR(MIRR_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_port (
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .busy(busy), .mirror(mirror_q), .status(status),
    .wr_accept(wr_accept), .rd_status(rd_status), .reject(reject),
    .host_rdata(host_rdata)
  );

  cmc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_accept), .busy(busy), .apply(apply_now)
  );

  cmc_mode_resolve #(.FD_OK(FULL_DUPLEX_OK)) u_resolve (
    .raw(pend_q), .cfg(res_cfg), .full(res_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mirror_q    <= '0;
      pend_q      <= '0;
      mode_cfg    <= '0;
      full_duplex <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (wr_accept) begin
        mirror_q <= host_wdata;
        pend_q   <= host_wdata;
      end
      if (apply_now) begin
        mode_cfg    <= res_cfg;
        full_duplex <= res_full;
      end
      if (apply_now)      done_q <= 1'b1;
      else if (rd_status) done_q <= 1'b0;
      if (reject)         err_q <= 1'b1;
      else if (rd_status) err_q <= 1'b0;
    end
  end

  assign frame_wanted = mode_cfg[B_WANT] & mode_cfg[B_DEC] & dec_ready;

  always_comb begin
    status          = '0;
    status[ST_DONE] = done_q;
    status[ST_WANT] = frame_wanted;
    status[ST_ERR]  = err_q;
  end

  assign irq_n = ~(done_q & irq_enable);
endmodule

// File: rtl/cmc_ctrl_chk.sv
module cmc_ctrl_chk
  import cmc_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter bit FD_OK      = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [REG_W-1:0] host_wdata,
  input logic             irq_enable,
  input logic             irq_n,
  input logic             busy,
  input logic [REG_W-1:0] mode_cfg,
  input logic             full_duplex,
  input logic             wr_accept,
  input logic             apply_now,
  input logic             reject,
  input logic [REG_W-1:0] mirror,
  input logic             err
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 1;
  end

  AST_MIRROR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> mirror == $past(host_wdata));                          // R1
  AST_SETTLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    apply_now |-> busy_cnt == 32'(SETTLE_CYC - 1));                      // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_now |=> $stable(mode_cfg) && $stable(full_duplex));           // R2
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    apply_now |=> !busy);                                                // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> irq_enable);                                              // R3
  AST_DROP_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && host_wr |=> $stable(mirror));                                // R5
  AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err);                                                     // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cfg[15] == 1'b0 && mode_cfg[14] == 1'b0 && mode_cfg[10] == 1'b0); // R6
  AST_HALF_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !FD_OK |-> !(mode_cfg[B_DEC] && mode_cfg[B_ENC]) && !full_duplex);  // R7
  AST_FULL_NO_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |-> (mode_cfg & TONE_MASK) == '0);                       // R8
  AST_RPT_VS_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cfg[B_ENC] |-> !mode_cfg[B_RPT]);                               // R9
endmodule

bind codec_mode_ctrl cmc_ctrl_chk #(
  .SETTLE_CYC(SETTLE_CYC), .FD_OK(FULL_DUPLEX_OK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
  .irq_enable(irq_enable), .irq_n(irq_n), .busy(busy), .mode_cfg(mode_cfg),
  .full_duplex(full_duplex), .wr_accept(wr_accept), .apply_now(apply_now),
  .reject(reject), .mirror(mirror_q), .err(err_q)
);

// File: tb/codec_mode_ctrl_test.sv
module codec_mode_ctrl_test;
  localparam int SETTLE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        irq_enable = 1'b0, dec_ready = 1'b0;
  logic [15:0] rdata_h, rdata_f, cfg_h, cfg_f;
  logic        irq_h, irq_f, busy_h, busy_f, full_h, full_f;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  codec_mode_ctrl #(.FULL_DUPLEX_OK(1'b0), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata_h),
    .irq_enable(irq_enable), .dec_ready(dec_ready), .irq_n(irq_h),
    .busy(busy_h), .mode_cfg(cfg_h), .full_duplex(full_h));

  codec_mode_ctrl #(.FULL_DUPLEX_OK(1'b1), .SETTLE_CYC(SETTLE)) uut_fd (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata_f),
    .irq_enable(irq_enable), .dec_ready(dec_ready), .irq_n(irq_f),
    .busy(busy_f), .mode_cfg(cfg_f), .full_duplex(full_f));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected resolved word, written from the requirement text
  function automatic logic [15:0] model(input logic [15:0] w, input bit fd);
    logic [15:0] e;
    e = w & 16'h3BFF;                              // R6
    if (w[1]) e[2] = 1'b0;                         // R9
    if (w[1:0] == 2'b11) begin
      if (fd) e = e & 16'hC41F;                    // R8
      else    e[1:0] = 2'b00;                      // R7
    end
    return e;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] dh, output logic [15:0] df);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1;
    dh = rdata_h; df = rdata_f;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_h) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] dh, df, prev_h, prev_f, w, eh, ef;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("reset busy", {busy_h, busy_f}, 0);
    check("reset cfg", {cfg_h, cfg_f}, 0);
    check("reset irq", {irq_h, irq_f}, 2'b11);
    rd(8'h40, dh, df);
    check("reset status", {dh, df}, 0);
    prev_h = '0; prev_f = '0;

    // sweep over the low mode bits with varied upper patterns
    for (int i = 0; i < 64; i++) begin
      w = 16'(i[4:0]) | ((i[5] ? 16'hFFE0 : 16'h2B40) ^ 16'(i * 16'h0460));
      irq_enable = i[0] ^ i[3];
      dec_ready  = i[1] ^ i[5];
      wr(8'h11, w);
      check("R2 busy start", {busy_h, busy_f}, 2'b11);
      check("R2 cfg hold half", cfg_h, prev_h);
      check("R2 cfg hold full", cfg_f, prev_f);
      wait_idle(n);
      check("R2 settle length", n, SETTLE);
      eh = model(w, 0); ef = model(w, 1);
      check("R6 R7 R9 cfg half", cfg_h, eh);
      check("R6 R8 R9 cfg full", cfg_f, ef);
      check("R7 full flag half", full_h, 0);
      check("R8 full flag full", full_f, w[1:0] == 2'b11);
      check("R3 irq", {irq_h, irq_f}, irq_enable ? 2'b00 : 2'b11);
      rd(8'h40, dh, df);
      check("R3 R10 status half", dh, 16'h8000 | (16'(eh[4] & eh[0] & dec_ready) << 8));
      check("R3 R10 status full", df, 16'h8000 | (16'(ef[4] & ef[0] & dec_ready) << 8));
      rd(8'h40, dh, df);
      check("R4 done cleared", {dh[15], df[15]}, 0);
      check("R4 irq released", {irq_h, irq_f}, 2'b11);
      rd(8'h3C, dh, df);
      check("R1 mirror", {dh, df}, {w, w});
      prev_h = eh; prev_f = ef;
    end

    // R10: frame wanted follows dec_ready live
    wr(8'h11, 16'h0011);
    wait_idle(n);
    rd(8'h40, dh, df);
    dec_ready = 1'b1;
    rd(8'h40, dh, df);
    check("R10 wanted on", {dh[8], df[8]}, 2'b11);
    dec_ready = 1'b0;
    rd(8'h40, dh, df);
    check("R10 wanted off", {dh[8], df[8]}, 0);
    prev_h = model(16'h0011, 0); prev_f = model(16'h0011, 1);

    // R5: access while busy
    irq_enable = 1'b1;
    wr(8'h11, 16'h0009);
    wr(8'h11, 16'h0002);
    rd(8'h3C, dh, df);
    check("R5 busy read zero", {dh, df}, 0);
    wait_idle(n);
    check("R5 dropped write cfg", {cfg_h, cfg_f}, {model(16'h0009, 0), model(16'h0009, 1)});
    rd(8'h40, dh, df);
    check("R5 sticky error", {dh, df}, {16'h8001, 16'h8001});
    rd(8'h40, dh, df);
    check("R4 error cleared", {dh, df}, 0);
    rd(8'h3C, dh, df);
    check("R5 mirror kept", {dh, df}, {16'h0009, 16'h0009});

    // R11: other addresses, R1: control address reads zero
    wr(8'h3C, 16'h1234);
    check("R11 no busy mirror addr", {busy_h, busy_f}, 0);
    wr(8'h40, 16'hFFFF);
    check("R11 no busy status addr", {busy_h, busy_f}, 0);
    wr(8'h12, 16'h0003);
    check("R11 no busy other addr", {busy_h, busy_f}, 0);
    repeat (SETTLE + 2) @(negedge clk);
    rd(8'h3C, dh, df);
    check("R11 mirror unchanged", {dh, df}, {16'h0009, 16'h0009});
    check("R11 cfg unchanged", {cfg_h, cfg_f}, {model(16'h0009, 0), model(16'h0009, 1)});
    rd(8'h11, dh, df);
    check("R1 ctrl reads zero", {dh, df}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule